// File: doc/BRIEF.md
# Always-On Interrupt Aggregator with Forwarded NMI

This block collects up to 32 interrupt lines in an always-on power domain and serves two consumers. Line 0 comes from an external non-maskable interrupt pin whose trigger type can be programmed. Lines 1 and above are level-high inputs. Every line passes through a synchronizer and then lands in a pending register.

The first output, `nmi_out`, is an active-high level for the main interrupt controller. It is driven only by line 0 and its enable bit. The second output, `cpu_irq`, goes to a management coprocessor. It combines all lines, filtered by enable, mask and response bits. A vector register returns a programmable base plus four times the index of the lowest active line.

Software reaches the registers over a small request/acknowledge bus. A bus state machine has two states. It sits in BUS_IDLE until `bus_req` is seen (transition *accept*), moves to BUS_ACCESS, and then returns to BUS_IDLE on the next cycle (transition *complete*). The write or read happens in BUS_ACCESS.

Line 0 has its own capture state machine with two states. NMI_CLEAR goes to NMI_HELD on *capture*: the programmed edge in edge modes, or the active level in level modes. NMI_HELD goes back to NMI_CLEAR on *release*: a write-1-clear in edge modes, or the inactive level in level modes.

Top module: `aon_irq_hub`

## Requirements
- R1: After reset, the pending, enable, mask, response and base registers read 0. The trigger register reads 2 (high level). The vector reads 0, and both `nmi_out` and `cpu_irq` are low.
- R2: A request sampled in BUS_IDLE is acknowledged in the following cycle for exactly one cycle, and `bus_rdata` is valid with that acknowledge. The offsets are: vector 0x00 (read-only), base 0x04, trigger 0x0C, pending 0x10, enable 0x40, mask 0x50 and response 0x60. Any other offset reads 0.
- R3: For lines 1 and above, the pending bit follows the synchronized input, and writes to those pending bits have no effect.
- R4: The trigger register bits [1:0] select the mode of line 0: 00 low level, 01 falling edge, 10 high level, 11 rising edge. In the level modes, pending bit 0 is set while the pin is at the active level and clear otherwise.
- R5: In the edge modes, pending bit 0 is set by the chosen edge and holds until a 1 is written to bit 0 of offset 0x10. In the level modes that write has no effect.
- R6: `nmi_out` is high exactly when pending bit 0 and enable bit 0 are both set. Enable bits 1 and above have no influence on it.
- R7: `cpu_irq` is high when some line has its pending and enable bits set and its mask and response bits clear.
- R8: Writing 1 to a response bit toggles it: the first write acknowledges the line and the second releases it. Writing 0 leaves the bit unchanged.
- R9: The vector reads base + 4 × the lowest index that qualifies under R7. It reads the base when no line qualifies.
- R10: A change on an input pin appears in the pending register, and at the outputs, three clock edges after it is driven (SYNC_STAGES + 1 with the default of two stages).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, sampled in BUS_IDLE |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | One-cycle access acknowledge |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| src_irq | input | NUM_SRC-1 | Level-high interrupt lines 1 and above |
| nmi_pin | input | 1 | External NMI pin (line 0) |
| nmi_out | output | 1 | Forwarded NMI level to the main controller |
| cpu_irq | output | 1 | Global interrupt to the coprocessor |

## Verification
The bus checks assume that `bus_req` is raised only while no acknowledge is outstanding, so every request meets BUS_IDLE. The stimulus therefore issues one access at a time and drops the request in the acknowledge cycle. The pending-tracking and capture checks assume that the input pins are quiet long enough to cross the synchronizer. The stimulus holds each pin level for at least four cycles before it reads or switches the trigger mode, so every edge that matters has been seen before the next step.

// File: rtl/aon_irq_pkg.sv
package aon_irq_pkg;

    localparam int REG_W      = 32;
    localparam int REG_ADDR_W = 8;

    localparam logic [REG_ADDR_W-1:0] OFS_VECTOR = 8'h00;
    localparam logic [REG_ADDR_W-1:0] OFS_BASE   = 8'h04;
    localparam logic [REG_ADDR_W-1:0] OFS_TRIG   = 8'h0C;
    localparam logic [REG_ADDR_W-1:0] OFS_PEND   = 8'h10;
    localparam logic [REG_ADDR_W-1:0] OFS_ENABLE = 8'h40;
    localparam logic [REG_ADDR_W-1:0] OFS_MASK   = 8'h50;
    localparam logic [REG_ADDR_W-1:0] OFS_RESP   = 8'h60;

    typedef enum logic [1:0] {
        TRIG_LVL_LO = 2'b00,
        TRIG_FALL   = 2'b01,
        TRIG_LVL_HI = 2'b10,
        TRIG_RISE   = 2'b11
    } trig_mode_e;

    typedef enum logic {
        BUS_IDLE,
        BUS_ACCESS
    } bus_state_e;

    typedef enum logic {
        NMI_CLEAR,
        NMI_HELD
    } nmi_state_e;

endpackage

// File: rtl/aon_irq_sync.sv
module aon_irq_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/aon_irq_nmi_trig.sv
module aon_irq_nmi_trig
    import aon_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_sync,
    input  trig_mode_e mode,
    input  logic       clr_req,
    output logic       pend
);

    nmi_state_e state_q, state_d;
    logic       pin_prev_q;
    logic       rise, fall, is_edge;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_prev_q <= 1'b0;
        else        pin_prev_q <= pin_sync;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= NMI_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        rise    = pin_sync & ~pin_prev_q;
        fall    = ~pin_sync & pin_prev_q;
        is_edge = mode[0];
        state_d = state_q;
        unique case (mode)
            TRIG_LVL_LO: state_d = pin_sync ? NMI_CLEAR : NMI_HELD;
            TRIG_LVL_HI: state_d = pin_sync ? NMI_HELD : NMI_CLEAR;
            TRIG_RISE: begin
                if (rise)                               state_d = NMI_HELD;
                else if (state_q == NMI_HELD && clr_req) state_d = NMI_CLEAR;
            end
            TRIG_FALL: begin
                if (fall)                               state_d = NMI_HELD;
                else if (state_q == NMI_HELD && clr_req) state_d = NMI_CLEAR;
            end
        endcase
    end

    // outputs
    always_comb begin
        pend = (state_q == NMI_HELD);
    end

    // R5
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_edge && pend && !clr_req) |=> (pend || !is_edge));

    // R5
    edge_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TRIG_RISE && rise) |=> pend);

endmodule

// File: rtl/aon_irq_vector.sv
module aon_irq_vector
    import aon_irq_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SRC-1:0]         active,
    input  logic [REG_W-1:0]           base,
    output logic [REG_W-1:0]           vector,
    output logic                       any_active
);

    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic [IDX_W-1:0] idx;

    always_comb begin
        idx        = '0;
        any_active = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (!any_active && active[i]) begin
                idx        = IDX_W'(i);
                any_active = 1'b1;
            end
        end
        vector = base + (REG_W'(idx) << 2);
    end

    // R9
    vec_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_active |-> active[idx]);

    // R9
    vec_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_active |-> ((active & ((NUM_SRC'(1) << idx) - NUM_SRC'(1))) == '0));

    // R9
    vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active == '0) |-> (idx == '0));

endmodule

// File: rtl/aon_irq_hub.sv
module aon_irq_hub
    import aon_irq_pkg::*;
#(
    parameter int NUM_SRC     = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_req,
    input  logic                   bus_we,
    input  logic [REG_ADDR_W-1:0]  bus_addr,
    input  logic [REG_W-1:0]       bus_wdata,
    output logic                   bus_ack,
    output logic [REG_W-1:0]       bus_rdata,
    input  logic [NUM_SRC-1:1]     src_irq,
    input  logic                   nmi_pin,
    output logic                   nmi_out,
    output logic                   cpu_irq
);

    bus_state_e             state_q, state_d;
    logic                   we_q;
    logic [REG_ADDR_W-1:0]  addr_q;
    logic [REG_W-1:0]       wdata_q;

    logic [REG_W-1:0]       base_q;
    trig_mode_e             trig_q;
    logic [NUM_SRC-1:0]     en_q, mask_q, resp_q;
    logic [NUM_SRC-1:1]     pend_hi_q;
    logic                   pend0;
    logic [NUM_SRC-1:0]     pend, active;
    logic [NUM_SRC-1:0]     sync_all;
    logic [REG_W-1:0]       vector;
    logic                   any_active;
    logic                   wr_fire, clr_req;

    // synchronizers for every line, NMI pin in bit 0
    aon_irq_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({src_irq, nmi_pin}),
        .sync_out (sync_all)
    );

    // bus state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE:   if (bus_req) state_d = BUS_ACCESS;
            BUS_ACCESS: state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (state_q == BUS_IDLE && bus_req) begin
            we_q    <= bus_we;
            addr_q  <= bus_addr;
            wdata_q <= bus_wdata;
        end
    end

    assign wr_fire = (state_q == BUS_ACCESS) && we_q;
    assign clr_req = wr_fire && (addr_q == OFS_PEND) && wdata_q[0];

    // register writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            trig_q <= TRIG_LVL_HI;
            en_q   <= '0;
            mask_q <= '0;
            resp_q <= '0;
        end else if (wr_fire) begin
            case (addr_q)
                OFS_BASE:   base_q <= wdata_q;
                OFS_TRIG:   trig_q <= trig_mode_e'(wdata_q[1:0]);
                OFS_ENABLE: en_q   <= wdata_q[NUM_SRC-1:0];
                OFS_MASK:   mask_q <= wdata_q[NUM_SRC-1:0];
                OFS_RESP:   resp_q <= resp_q ^ wdata_q[NUM_SRC-1:0];
                default: ;
            endcase
        end
    end

    // level-high lines track their synchronized inputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_hi_q <= '0;
        else        pend_hi_q <= sync_all[NUM_SRC-1:1];
    end

    aon_irq_nmi_trig u_nmi (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_sync (sync_all[0]),
        .mode     (trig_q),
        .clr_req  (clr_req),
        .pend     (pend0)
    );

    assign pend   = {pend_hi_q, pend0};
    assign active = pend & en_q & ~mask_q & ~resp_q;

    aon_irq_vector #(.NUM_SRC(NUM_SRC)) u_vec (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .base       (base_q),
        .vector     (vector),
        .any_active (any_active)
    );

    // outputs
    always_comb begin
        bus_ack   = (state_q == BUS_ACCESS);
        bus_rdata = '0;
        if (state_q == BUS_ACCESS && !we_q) begin
            case (addr_q)
                OFS_VECTOR: bus_rdata = vector;
                OFS_BASE:   bus_rdata = base_q;
                OFS_TRIG:   bus_rdata = REG_W'(trig_q);
                OFS_PEND:   bus_rdata = REG_W'(pend);
                OFS_ENABLE: bus_rdata = REG_W'(en_q);
                OFS_MASK:   bus_rdata = REG_W'(mask_q);
                OFS_RESP:   bus_rdata = REG_W'(resp_q);
                default:    bus_rdata = '0;
            endcase
        end
        nmi_out = pend0 & en_q[0];
        cpu_irq = any_active;
    end

    // R2
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    // R2
    req_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> bus_ack);

    // R8
    resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_fire && addr_q == OFS_RESP) |=> $stable(resp_q));

    // R3
    pend_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(sync_all[NUM_SRC-1:1]) |=> $stable(pend_hi_q));

    // R6
    nmi_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_out) |-> (pend0 && en_q[0]));

endmodule

// File: tb/aon_irq_hub_tb.sv
module aon_irq_hub_tb;
    import aon_irq_pkg::*;

    localparam int NSRC = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_req = 1'b0;
    logic              bus_we = 1'b0;
    logic [7:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic              bus_ack;
    logic [31:0]       bus_rdata;
    logic [NSRC-1:1]   src_irq = '0;
    logic              nmi_pin = 1'b0;
    logic              nmi_out;
    logic              cpu_irq;

    int n_checks = 0;
    int n_fail   = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    bit          chk_q[$];

    always #2.5 clk = ~clk;

    aon_irq_hub #(.NUM_SRC(NSRC), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .src_irq(src_irq), .nmi_pin(nmi_pin),
        .nmi_out(nmi_out), .cpu_irq(cpu_irq)
    );

    // monitor: pops scoreboard entries as acknowledges appear
    always @(negedge clk) begin
        logic [31:0] e;
        string       t;
        bit          c;
        if (rst_n && bus_ack) begin
            if (exp_q.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL R2 unexpected ack: actual rdata %h expected no ack", bus_rdata);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                c = chk_q.pop_front();
                if (c) begin
                    n_checks++;
                    if (bus_rdata !== e) begin
                        n_fail++;
                        $display("FAIL %s: actual %h expected %h", t, bus_rdata, e);
                    end
                end
            end
        end
    end

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        exp_q.push_back('0); tag_q.push_back("write"); chk_q.push_back(1'b0);
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        exp_q.push_back(e); tag_q.push_back(t); chk_q.push_back(1'b1);
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_bit(input string t, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", t, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        settle(1);

        // R1 reset state
        check_bit("R1 nmi_out", nmi_out, 1'b0);
        check_bit("R1 cpu_irq", cpu_irq, 1'b0);
        bus_read(OFS_PEND,   32'h0, "R1 pending");
        bus_read(OFS_ENABLE, 32'h0, "R1 enable");
        bus_read(OFS_MASK,   32'h0, "R1 mask");
        bus_read(OFS_RESP,   32'h0, "R1 response");
        bus_read(OFS_BASE,   32'h0, "R1 base");
        bus_read(OFS_TRIG,   32'h2, "R1 trigger");
        bus_read(OFS_VECTOR, 32'h0, "R1 vector");

        // R2 register access
        bus_write(OFS_BASE, 32'h0000_1000);
        bus_read(OFS_BASE, 32'h0000_1000, "R2 base readback");
        bus_write(OFS_ENABLE, 32'hFFFF_FFFE);
        bus_read(OFS_ENABLE, 32'hFFFF_FFFE, "R2 enable readback");
        bus_read(8'h20, 32'h0, "R2 unmapped offset");

        // R3 level lines, R7 global output, R6 isolation, R9 vector
        src_irq[5] = 1'b1;
        settle(4);
        bus_read(OFS_PEND, 32'h20, "R3 pending line 5");
        check_bit("R7 cpu_irq line 5", cpu_irq, 1'b1);
        check_bit("R6 nmi_out unaffected by enable 1..31", nmi_out, 1'b0);
        bus_read(OFS_VECTOR, 32'h1014, "R9 vector line 5");
        src_irq[3] = 1'b1;
        settle(4);
        bus_read(OFS_VECTOR, 32'h100C, "R9 vector lowest line 3");
        bus_write(OFS_PEND, 32'hFFFF_FFFF);
        settle(2);
        bus_read(OFS_PEND, 32'h28, "R3 pending write ignored");

        // R7 mask
        bus_write(OFS_MASK, 32'h08);
        bus_read(OFS_VECTOR, 32'h1014, "R7 mask hides line 3");
        bus_write(OFS_MASK, 32'h28);
        settle(1);
        check_bit("R7 cpu_irq all masked", cpu_irq, 1'b0);
        bus_read(OFS_VECTOR, 32'h1000, "R9 vector none active");
        bus_write(OFS_MASK, 32'h0);

        // R8 response toggle
        bus_write(OFS_RESP, 32'h20);
        bus_read(OFS_RESP, 32'h20, "R8 response set");
        bus_read(OFS_VECTOR, 32'h100C, "R8 vector skips acked line");
        bus_write(OFS_RESP, 32'h08);
        settle(1);
        check_bit("R8 cpu_irq all acked", cpu_irq, 1'b0);
        bus_read(OFS_RESP, 32'h28, "R8 response both");
        bus_write(OFS_RESP, 32'h20);
        bus_read(OFS_RESP, 32'h08, "R8 response released");
        settle(1);
        check_bit("R8 cpu_irq after release", cpu_irq, 1'b1);
        bus_read(OFS_VECTOR, 32'h1014, "R8 vector after release");
        bus_write(OFS_RESP, 32'h08);
        src_irq = '0;
        settle(4);
        bus_read(OFS_PEND, 32'h0, "R3 pending follows drop");
        check_bit("R7 cpu_irq idle", cpu_irq, 1'b0);

        // R4 high level on line 0
        bus_write(OFS_ENABLE, 32'h1);
        nmi_pin = 1'b1;
        settle(4);
        bus_read(OFS_PEND, 32'h1, "R4 high level pending");
        check_bit("R6 nmi_out high level", nmi_out, 1'b1);
        check_bit("R7 cpu_irq from line 0", cpu_irq, 1'b1);
        bus_read(OFS_VECTOR, 32'h1000, "R9 vector line 0");
        nmi_pin = 1'b0;
        settle(4);
        bus_read(OFS_PEND, 32'h0, "R4 high level release");
        check_bit("R6 nmi_out released", nmi_out, 1'b0);

        // R5 rising edge
        bus_write(OFS_TRIG, 32'h3);
        nmi_pin = 1'b1;
        settle(4);
        check_bit("R5 rising capture", nmi_out, 1'b1);
        nmi_pin = 1'b0;
        settle(4);
        bus_read(OFS_PEND, 32'h1, "R5 rising held after pin low");
        bus_write(OFS_PEND, 32'h1);
        settle(2);
        check_bit("R5 rising cleared", nmi_out, 1'b0);
        bus_read(OFS_PEND, 32'h0, "R5 pending cleared");

        // R6 enable gating
        nmi_pin = 1'b1;
        settle(4);
        bus_write(OFS_ENABLE, 32'h0);
        settle(2);
        check_bit("R6 nmi_out disabled", nmi_out, 1'b0);
        bus_read(OFS_PEND, 32'h1, "R6 pending kept while disabled");
        bus_write(OFS_ENABLE, 32'h1);
        settle(2);
        check_bit("R6 nmi_out re-enabled", nmi_out, 1'b1);
        bus_write(OFS_PEND, 32'h1);
        settle(4);
        bus_read(OFS_PEND, 32'h0, "R5 no recapture without edge");

        // R5 falling edge
        bus_write(OFS_TRIG, 32'h1);
        nmi_pin = 1'b0;
        settle(4);
        bus_read(OFS_PEND, 32'h1, "R5 falling capture");
        nmi_pin = 1'b1;
        settle(4);
        bus_read(OFS_PEND, 32'h1, "R5 falling held");
        bus_write(OFS_PEND, 32'h1);
        bus_read(OFS_PEND, 32'h0, "R5 falling cleared");

        // R4 low level, R5 clear ignored in level mode
        bus_write(OFS_TRIG, 32'h0);
        settle(4);
        bus_read(OFS_PEND, 32'h0, "R4 low level pin high");
        nmi_pin = 1'b0;
        settle(4);
        bus_read(OFS_PEND, 32'h1, "R4 low level pin low");
        check_bit("R6 nmi_out low level", nmi_out, 1'b1);
        bus_write(OFS_PEND, 32'h1);
        settle(2);
        bus_read(OFS_PEND, 32'h1, "R5 clear ignored in level mode");
        nmi_pin = 1'b1;
        settle(4);
        bus_read(OFS_PEND, 32'h0, "R4 low level release");

        // R10 latency on line 7
        bus_write(OFS_ENABLE, 32'h80);
        settle(1);
        src_irq[7] = 1'b1;
        settle(2);
        check_bit("R10 not yet after two edges", cpu_irq, 1'b0);
        settle(1);
        check_bit("R10 visible after three edges", cpu_irq, 1'b1);

        settle(4);
        finish_run();
    end

endmodule